// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system-on-chip. Software reaches it through a simple word-wide register port: one write strobe with an address and data, and a combinational read path selected by a read address. A down-counter runs from a programmable reload value. Software keeps the system alive by writing a fixed 16-bit key to the restart location before the count runs out. A write carrying any other value changes nothing.

When the counter is already at zero and one more tick arrives, the watchdog expires. The counter reloads and a sticky status flag is set. Each of three outputs (system reset request, interrupt, external signal) then pulses, but only if its own enable bit is set. All three pulses last for a programmed number of clock cycles. Ticks come either from every bus clock cycle or from a slower reference-clock enable input. The reset input is asynchronous, and its release is synchronised inside the block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter and the reload register both read 0x03EF1480, the pulse-length register reads 0x000000FF, control and status read 0, and all three outputs are low.
- R2: Byte offsets are: counter 0x00 (read-only), reload 0x04, restart 0x08 (write-only), control 0x0C, status 0x10 (read-only), clear 0x14 (write-only), pulse length 0x18. Write-only locations and unmapped offsets read 0. Control bits 31:5 read 0. A write to the counter offset has no effect.
- R3: A write to 0x08 whose bits 15:0 equal 0x5AB9 loads the counter from the reload register, whatever bits 31:16 hold. A write with any other low half leaves the counter unchanged.
- R4: Control bit 0 is the run enable. While it is set, the counter drops by one on every tick. While it is clear, the counter holds its value.
- R5: Control bit 4 picks the tick. With 0, every clock cycle is a tick. With 1, only cycles in which `ref_tick` is high are ticks.
- R6: A tick that arrives while the counter is 0 is an expiry. The counter reloads from the reload register and status bit 0 becomes 1, so one period is reload+1 ticks.
- R7: Status bit 0 stays at 1 until a write to 0x14 with bit 0 set. Writing 0 there has no effect, and an expiry in the same cycle as a clear leaves the flag set.
- R8: Control bit 1 enables `sys_rst_o`, bit 2 enables `irq_o` and bit 3 enables `ext_o`. An output whose enable is set at expiry goes high from the next cycle for pulse-length+1 cycles. Outputs whose enable is clear stay low.
- R9: An expiry while a pulse is still running restarts that pulse's full length.
- R10: Writing the reload register does not change the counter. The new value only takes effect at the next restart or expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable from the slow reference clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset for the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| sys_rst_o | output | 1 | System reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_o | output | 1 | External signal pulse |

## Verification
The counter is visible on every cycle through its read offset. A wrong decrement, hold, reload or key decision therefore shows up at `rd_data` one clock after the edge that caused it. An error in expiry or in pulse timing appears on the three outputs in the cycle after the faulty edge. The bench's reference model is compared against these outputs on every clock, which covers the retrigger case and an early or late pulse end. A wrong sticky flag only shows when status is read, so status is read directly after expiries and around clear writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0]  OFF_COUNT   = 8'h00;
  localparam logic [7:0]  OFF_RELOAD  = 8'h04;
  localparam logic [7:0]  OFF_KICK    = 8'h08;
  localparam logic [7:0]  OFF_CTRL    = 8'h0C;
  localparam logic [7:0]  OFF_STATUS  = 8'h10;
  localparam logic [7:0]  OFF_CLEAR   = 8'h14;
  localparam logic [7:0]  OFF_PLEN    = 8'h18;

  localparam logic [15:0] KICK_KEY    = 16'h5AB9;
  localparam logic [31:0] RELOAD_RST  = 32'h03EF1480;
  localparam logic [31:0] PLEN_RST    = 32'h000000FF;

  localparam int NUM_OUT = 3;
  localparam int CTRL_W  = 5;

  typedef struct packed {
    logic use_ref;   // bit 4
    logic ext_en;    // bit 3
    logic irq_en;    // bit 2
    logic rst_en;    // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/wdt_reset_sync.sv
module wdt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload_val,
  output logic [LEN_W-1:0]  plen_val,
  output logic              kick,
  output logic              status
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [LEN_W-1:0] plen_q, plen_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             stat_q, stat_d;
  logic             wr_reload, wr_ctrl, wr_plen, wr_clr;

  // write decode
  always_comb begin
    wr_reload = wr_en && (wr_addr == ADDR_W'(OFF_RELOAD));
    wr_ctrl   = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
    wr_plen   = wr_en && (wr_addr == ADDR_W'(OFF_PLEN));
    wr_clr    = wr_en && (wr_addr == ADDR_W'(OFF_CLEAR)) && wr_data[0];
    kick      = wr_en && (wr_addr == ADDR_W'(OFF_KICK)) && (wr_data[15:0] == KICK_KEY);
  end

  // next state
  always_comb begin
    reload_d = reload_q;
    plen_d   = plen_q;
    ctrl_d   = ctrl_q;
    stat_d   = stat_q;
    if (wr_reload) reload_d = wr_data[CNT_W-1:0];
    if (wr_plen)   plen_d   = wr_data[LEN_W-1:0];
    if (wr_ctrl)   ctrl_d   = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (expire)      stat_d = 1'b1;
    else if (wr_clr) stat_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= CNT_W'(RELOAD_RST);
      plen_q   <= LEN_W'(PLEN_RST);
      ctrl_q   <= '0;
      stat_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      plen_q   <= plen_d;
      ctrl_q   <= ctrl_d;
      stat_q   <= stat_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = 32'h0;
    if (rd_addr == ADDR_W'(OFF_COUNT))       rd_data = 32'(cnt_val);
    else if (rd_addr == ADDR_W'(OFF_RELOAD)) rd_data = 32'(reload_q);
    else if (rd_addr == ADDR_W'(OFF_CTRL))   rd_data = 32'(ctrl_q);
    else if (rd_addr == ADDR_W'(OFF_STATUS)) rd_data = {31'h0, stat_q};
    else if (rd_addr == ADDR_W'(OFF_PLEN))   rd_data = 32'(plen_q);
  end

  assign ctrl       = ctrl_q;
  assign reload_val = reload_q;
  assign plen_val   = plen_q;
  assign status     = stat_q;

  // R7: expiry sets the flag
  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> status);
  // R7: flag stays set without a clear write
  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (status && !wr_clr) |=> status);
  // R10: reload value moves only on a reload write
  assert_reload_stable_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_reload |=> $stable(reload_val));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_en;
  logic             at_zero;

  always_comb begin
    tick_en = run && (use_ref ? ref_tick : 1'b1);
    at_zero = (cnt_q == '0);
    expire  = tick_en && !kick && at_zero;
    cnt_d   = cnt_q;
    if (kick)            cnt_d = reload_val;
    else if (tick_en) begin
      if (at_zero)       cnt_d = reload_val;
      else               cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(RELOAD_RST);
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: no tick and no kick means the count holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_en && !kick) |=> $stable(cnt));
  // R4: a tick on a nonzero count steps down by one
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_en && !kick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R3: a keyed restart loads the reload value
  assert_kick_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    kick |=> (cnt == $past(reload_val)));
  // R6: expiry reloads
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fire,
  input  logic [LEN_W-1:0] plen,
  output logic             active
);
  logic             act_q, act_d;
  logic [LEN_W-1:0] rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (fire) begin
      act_d = 1'b1;
      rem_d = plen;
    end else if (act_q) begin
      if (rem_q == '0) act_d = 1'b0;
      else             rem_d = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  assign active = act_q;

  // R8, R9: every fire (re)starts a pulse of full length
  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    fire |=> (active && rem_q == $past(plen)));
  // R8: an idle output stays low without a fire
  assert_pulse_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active && !fire) |=> !active);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              sys_rst_o,
  output logic              irq_o,
  output logic              ext_o
);
  logic             rst_ni;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] plen_val;
  logic             kick;
  logic             expire;
  logic             status;
  logic [NUM_OUT-1:0] out_en;
  logic [NUM_OUT-1:0] out_act;

  wdt_reset_sync u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cnt_val    (cnt),
    .expire     (expire),
    .ctrl       (ctrl),
    .reload_val (reload_val),
    .plen_val   (plen_val),
    .kick       (kick),
    .status     (status)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .run        (ctrl.run),
    .use_ref    (ctrl.use_ref),
    .ref_tick   (ref_tick),
    .kick       (kick),
    .reload_val (reload_val),
    .cnt        (cnt),
    .expire     (expire)
  );

  assign out_en = {ctrl.ext_en, ctrl.irq_en, ctrl.rst_en};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    wdt_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk    (clk),
      .rst_ni (rst_ni),
      .fire   (expire && out_en[g]),
      .plen   (plen_val),
      .active (out_act[g])
    );
  end

  assign sys_rst_o = out_act[0];
  assign irq_o     = out_act[1];
  assign ext_o     = out_act[2];

  // R6: expiry only comes from a zero count
  assert_expire_zero_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |-> (cnt == '0));
  // R6: status rises only after an expiry
  assert_status_cause_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(status) |-> $past(expire));
endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        sys_rst_o, irq_o, ext_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  keyed_wdt i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o), .ext_o(ext_o)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_load;
  logic [4:0]  m_ctrl;
  logic [15:0] m_len;
  logic        m_stat;
  logic [2:0]  m_act;
  int          m_rem [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 32'h03EF1480; m_load = 32'h03EF1480;
      m_ctrl = 0; m_len = 16'hFF; m_stat = 0; m_act = 0;
      for (int i = 0; i < 3; i++) m_rem[i] = 0;
    end else begin
      bit tick, ex, keyok;
      keyok = wr_en && wr_addr == 8'h08 && wr_data[15:0] == 16'h5AB9;
      tick  = m_ctrl[0] && (m_ctrl[4] ? ref_tick : 1'b1);
      ex = 0;
      if (keyok) m_cnt = m_load;
      else if (tick) begin
        if (m_cnt == 0) begin ex = 1; m_cnt = m_load; end
        else m_cnt = m_cnt - 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (ex && m_ctrl[i+1]) begin m_act[i] = 1; m_rem[i] = m_len; end
        else if (m_act[i]) begin
          if (m_rem[i] == 0) m_act[i] = 0; else m_rem[i] = m_rem[i] - 1;
        end
      end
      if (ex) m_stat = 1;
      else if (wr_en && wr_addr == 8'h14 && wr_data[0]) m_stat = 0;
      if (wr_en) begin
        case (wr_addr)
          8'h04: m_load = wr_data;
          8'h0C: m_ctrl = wr_data[4:0];
          8'h18: m_len  = wr_data[15:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (rd_addr rests on the counter)
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n === 1'b1) begin
        chk("R4 counter vs model", rd_data, m_cnt);
        chk("R8 outputs vs model", {29'h0, ext_o, irq_o, sys_rst_o}, {29'h0, m_act});
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    rd_addr = a;
    #1 chk(tag, rd_data, exp);
    rd_addr = 8'h00;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    rst_n = 0; ref_tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1 counter reset", 8'h00, 32'h03EF1480);
    rd("R1 reload reset",  8'h04, 32'h03EF1480);
    rd("R1 control reset", 8'h0C, 32'h0);
    rd("R1 status reset",  8'h10, 32'h0);
    rd("R1 length reset",  8'h18, 32'hFF);
    #1 chk("R1 outputs low", {29'h0, ext_o, irq_o, sys_rst_o}, 32'h0);

    // R2 map details
    wr(8'h0C, 32'hFFFF_FFE0);
    rd("R2 control reserved bits", 8'h0C, 32'h0);
    wr(8'h0C, 32'h0000_0016);
    rd("R2 control readback", 8'h0C, 32'h16);
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h5);
    rd("R2 counter write ignored", 8'h00, 32'h03EF1480);
    rd("R2 restart reads zero", 8'h08, 32'h0);
    rd("R2 clear reads zero", 8'h14, 32'h0);
    rd("R2 unmapped reads zero", 8'h1C, 32'h0);

    // R10 reload write does not touch the counter
    wr(8'h04, 32'd10);
    rd("R10 counter unchanged", 8'h00, 32'h03EF1480);
    // R3 key handling
    wr(8'h08, 32'h0000_5AB8);
    rd("R3 wrong key ignored", 8'h00, 32'h03EF1480);
    wr(8'h08, 32'hFFFF_5AB9);
    rd("R3 keyed restart", 8'h00, 32'd10);

    // R6/R8 expiry with reset and interrupt enabled
    wr(8'h18, 32'd3);
    wr(8'h0C, 32'h7);
    repeat (10) @(negedge clk);
    rd("R6 status set at expiry", 8'h10, 32'h1);
    #1 chk("R8 reset and irq pulse, ext off", {29'h0, ext_o, irq_o, sys_rst_o}, 32'h3);
    repeat (3) @(negedge clk);
    #2 chk("R8 pulse still high", {31'h0, sys_rst_o}, 32'h1);
    @(negedge clk);
    #2 chk("R8 pulse ended", {31'h0, sys_rst_o}, 32'h0);

    // R7 sticky status
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h0);
    rd("R7 clear with zero ignored", 8'h10, 32'h1);
    wr(8'h14, 32'h1);
    rd("R7 clear", 8'h10, 32'h0);

    // R4 hold while disabled
    wr(8'h08, 32'h5AB9);
    repeat (5) @(negedge clk);
    rd("R4 disabled holds", 8'h00, 32'd10);

    // R5 reference tick source
    wr(8'h0C, 32'h19);
    repeat (4) @(negedge clk);
    rd("R5 no ref tick holds", 8'h00, 32'd10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 ref_tick = 1;
      @(negedge clk); #1 ref_tick = 0;
      repeat (2) @(negedge clk);
    end
    rd("R5 three ref ticks", 8'h00, 32'd7);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 ref_tick = 1;
      @(negedge clk); #1 ref_tick = 0;
    end
    repeat (2) @(negedge clk);
    #2 chk("R8 ext pulse from ref expiry", {29'h0, ext_o, irq_o, sys_rst_o}, 32'h4);
    rd("R6 status after ref expiry", 8'h10, 32'h1);

    // R9 retrigger: period 3 ticks, pulse 21 cycles
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'd2);
    wr(8'h18, 32'd20);
    wr(8'h08, 32'h5AB9);
    wr(8'h0C, 32'h5);
    repeat (60) @(negedge clk);
    #2 chk("R9 irq held by retrigger", {31'h0, irq_o}, 32'h1);
    // R7 clear attempts during running expiries
    for (int i = 0; i < 6; i++) wr(8'h14, 32'h1);
    wr(8'h0C, 32'h0);
    rd("R7 flag after clears and expiries", 8'h10, {31'h0, m_stat});
    repeat (30) @(negedge clk);
    #2 chk("R8 outputs idle after stop", {29'h0, ext_o, irq_o, sys_rst_o}, 32'h0);

    summary();
  end
endmodule